// File: doc/BRIEF.md
# Module Identification Memory Target on a Two-Wire Bus

This block is a target on an I2C bus that holds a 256-byte identification memory for a memory module. A host addresses it with a seven-bit device address. The upper four bits of that address are fixed at `1010`. The lower three bits come from strap inputs wired on the board. Once addressed, the host can move the internal byte pointer, read any number of bytes in order, or write bytes one after another.

The memory comes out of reset with a small factory header already in place, and the consistency byte at location 63 already matches that header. A lock input protects the lower half of the array. While the lock input is high, the target still acknowledges writes aimed at that half, but it leaves the stored bytes unchanged. The upper half stays writable at all times.

A status output reports whether the stored consistency byte agrees with the contents it covers. The block samples SCL and SDA with its own system clock and only ever pulls SDA low. It does not stretch the clock.

Top module: `spd_target`

## Requirements
- R1: After reset the memory holds 0x80, 0x08, 0x07, 0x0D, 0x0A at bytes 0 to 4 and 0xA6 at byte 63, every other byte is 0x00, and `csum_bad` is low.
- R2: The target acknowledges only an address byte whose upper seven bits equal {4'b1010, strap[2:0]}, with bit 0 selecting read (1) or write (0). Any other address byte is left unacknowledged, and the transfer that follows neither moves the pointer nor changes memory.
- R3: In a write transfer, the first byte after the address byte loads the byte pointer. A later read, either after a repeated START or in a new transfer, starts at that location.
- R4: Reads return bytes in order, most significant bit first. The pointer advances after every byte read and wraps from 255 to 0.
- R5: In a write transfer, each data byte after the pointer byte is stored at the pointer and acknowledged. The pointer then advances, wrapping from 255 to 0.
- R6: While `lock_en` is high, data bytes aimed at locations 0 to 127 are acknowledged, the pointer advances, and memory stays unchanged. Writes to 128 to 255 are stored regardless of `lock_en`.
- R7: `csum_bad` is high exactly when byte 63 differs from the low 8 bits of the arithmetic sum of bytes 0 to 62. It is re-evaluated after every write.
- R8: A STOP or a repeated START at any bit position sends the target back to waiting for an address byte. A data byte that was only partly received is discarded.
- R9: `sda_oe` high means SDA is pulled low. The target starts pulling only while SCL is low. It pulls on the ninth clock to acknowledge, and it stops driving when the host answers a read byte with a NACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired value, including this target's own drive) |
| sda_oe | output | 1 | When high, the data line is pulled low |
| strap | input | 3 | Board straps for the low three device-address bits |
| lock_en | input | 1 | Write protection for locations 0 to 127 |
| csum_bad | output | 1 | Stored consistency byte disagrees with bytes 0 to 62 |

## Verification
The assertions check on every cycle that stores obey the lock rule, that a permitted store lands with the presented data, and that an idle target never drives the line. They also check that the bit counter stays within a byte plus acknowledge, and that the target starts pulling SDA only while SCL is low. Other properties show only in the bench's bus scenarios. These are address filtering against the straps, pointer wrap in both directions, aborting a byte with a STOP or repeated START part-way through, and the status output following the contents after mixed random writes.

// File: rtl/spd_pkg.sv
// Package: shared constants, protocol state type and the power-on
// contents of the identification memory.
package spd_pkg;

    localparam int           BYTE_W     = 8;
    localparam logic [3:0]   DEV_PREFIX = 4'b1010;
    localparam int           HDR_LEN    = 5;
    localparam int           CSUM_IDX   = 63;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } spd_state_e;

    // Header byte k of the factory image (k < HDR_LEN).
    function automatic logic [BYTE_W-1:0] spd_header(input int k);
        case (k)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h07;
            3:       return 8'h0D;
            4:       return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    // Power-on value of location idx; the consistency byte is derived.
    function automatic logic [BYTE_W-1:0] spd_default_byte(input int idx);
        logic [BYTE_W-1:0] acc;
        acc = '0;
        if (idx == CSUM_IDX) begin
            for (int k = 0; k < HDR_LEN; k++) acc = acc + spd_header(k);
        end else begin
            acc = spd_header(idx);
        end
        return acc;
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
// Bus line conditioner.
// Brings SCL and SDA into the clk domain, then reports SCL edges and
// START/STOP conditions as one-cycle pulses.
// Assumes the bus runs many times slower than clk.
module spd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains and one-cycle history; the bus idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_sync[SYNC_STAGES-1];
            sda_prev <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_q     = scl_sync[SYNC_STAGES-1];
        sda_q     = sda_sync[SYNC_STAGES-1];
        scl_rise  = !scl_prev && scl_q;
        scl_fall  = scl_prev && !scl_q;
        start_det = scl_prev && scl_q && sda_prev && !sda_q;
        stop_det  = scl_prev && scl_q && !sda_prev && sda_q;
    end

endmodule

// File: rtl/spd_link.sv
// Bus protocol engine.
// Decodes the address byte, the pointer byte, and the data bytes.
// Acknowledges each accepted byte and serialises read data MSB first.
// Owns the byte pointer.
// Assumes the line events come from spd_line_sync. Read data is
// combinational from the store at the current pointer.
module spd_link
    import spd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_q,
    input  logic                sda_q,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [2:0]          strap,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   ptr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                sda_oe
);

    spd_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_read;
    logic              host_nack;
    logic              byte_full;

    assign byte_full = (bitcnt == 4'd8);

    // Main transfer sequencer: bus conditions take priority over bit traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            rw_read   <= 1'b0;
            host_nack <= 1'b0;
            ptr       <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            sda_oe    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && byte_full) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == {DEV_PREFIX, strap}) begin
                                    rw_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADDR) begin
                                ptr    <= ADDR_W'(shreg);
                                sda_oe <= 1'b1;
                                state  <= ST_WADDR_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_read) begin
                                shreg  <= rd_data;
                                sda_oe <= !rd_data[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= !shreg[3'd7 - bitcnt[2:0]];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_nack <= sda_q;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (!host_nack) begin
                                shreg  <= rd_data;
                                sda_oe <= !rd_data[7];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R9: the target begins pulling the data line only while the clock line is low.
    a_r9_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);

    // R8: a target waiting for an address byte never drives the line.
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R9: the bit counter never passes eight data bits.
    a_r9_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);

    // R8: a STOP always lands the engine in the idle state.
    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

endmodule

// File: rtl/spd_store.sv
// Identification memory array.
// Loads the factory image at reset, applies byte stores subject to the
// lower-half lock, and compares the consistency byte with the running
// sum of the bytes it covers.
// Assumes at most one store per cycle. Reads are combinational.
module spd_store
    import spd_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int LOCK_SPAN = 128,
    parameter int CSUM_POS  = CSUM_IDX,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              csum_bad
);

    localparam logic [ADDR_W-1:0] LOCK_LIMIT = ADDR_W'(LOCK_SPAN);

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] sum_c;
    logic              refused;

    assign refused = lock_en && (wr_addr < LOCK_LIMIT);

    // Array storage: factory image on reset, gated stores afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= spd_default_byte(i);
        end else if (wr_en && !refused) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read port and consistency comparison, modulo-256 sum.
    always_comb begin
        rd_data = mem_q[rd_addr];
        sum_c   = '0;
        for (int i = 0; i < CSUM_POS; i++) sum_c = sum_c + mem_q[i];
        csum_bad = (sum_c != mem_q[CSUM_POS]);
    end

    // R6: a store aimed at a locked location leaves it as it was.
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_en && (wr_addr < LOCK_LIMIT))
            |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr])));

    // R5: a permitted store lands with the presented data.
    a_r5_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(lock_en && (wr_addr < LOCK_LIMIT)))
            |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/spd_target.sv
// Top level: identification memory target on a two-wire bus.
// Wires the line conditioner, the protocol engine and the array.
// Assumes SDA is open-drain: sda_in carries the wired line level.
module spd_target
    import spd_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int LOCK_SPAN   = 128,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] strap,
    input  logic       lock_en,
    output logic       csum_bad
);

    logic              scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] ptr, wr_addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, rd_data;

    spd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    spd_link #(.ADDR_W(ADDR_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_q     (scl_q),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    spd_store #(.DEPTH(DEPTH), .LOCK_SPAN(LOCK_SPAN)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_en  (lock_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .csum_bad (csum_bad)
    );

endmodule

// File: tb/spd_target_bench.sv
`timescale 1ns/1ps
module spd_target_bench;

    localparam int Q = 8;   // clk cycles per quarter bus bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic       lock_en = 1'b0;
    logic       sda_oe;
    logic       csum_bad;
    logic       sda_line;

    int         checks = 0;
    int         fails = 0;
    logic [7:0] model [256];
    logic [7:0] mptr = 8'd0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    spd_target u_spd_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .strap    (strap),
        .lock_en  (lock_en),
        .csum_bad (csum_bad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_bad();
        logic [7:0] s = 8'd0;
        for (int i = 0; i < 63; i++) s = s + model[i];
        return s != model[63];
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit nack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); nack = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit last, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        sda_m = last; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
        sda_m = 1'b1; wq();
    endtask

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    // Write n bytes starting at a; data is random or an incrementing pattern.
    task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed, input bit rnd);
        bit nk;
        logic [7:0] d;
        bus_start();
        send_byte(dev(1'b0), nk); check(!nk, "R2 device address ack", nk, 0);
        send_byte(a, nk);         check(!nk, "R3 pointer byte ack", nk, 0);
        mptr = a;
        for (int k = 0; k < n; k++) begin
            d = rnd ? 8'($urandom) : 8'(seed + k);
            send_byte(d, nk);
            check(!nk, "R5 data byte ack", nk, 0);
            if (!(lock_en && mptr < 8'd128)) model[mptr] = d;
            mptr = mptr + 8'd1;
        end
        bus_stop();
        wq();
        check(csum_bad == exp_bad(), "R7 status after write", csum_bad, exp_bad());
    endtask

    // Read n bytes; set the pointer first (repeated START) when setp is high.
    task automatic do_read(input bit setp, input logic [7:0] a, input int n, input string req);
        bit nk;
        logic [7:0] b;
        bus_start();
        if (setp) begin
            send_byte(dev(1'b0), nk);
            send_byte(a, nk);
            mptr = a;
            sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
        end
        send_byte(dev(1'b1), nk); check(!nk, "R2 read address ack", nk, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            check(b == model[mptr], req, b, model[mptr]);
            mptr = mptr + 8'd1;
        end
        bus_stop();
        check(sda_oe == 1'b0, "R9 line released after NACK", sda_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        bit nk;
        logic [7:0] b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        model[0] = 8'h80; model[1] = 8'h08; model[2] = 8'h07;
        model[3] = 8'h0D; model[4] = 8'h0A; model[63] = 8'hA6;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(csum_bad == 1'b0, "R1 status after reset", csum_bad, 0);
        check(sda_oe == 1'b0, "R9 idle line after reset", sda_oe, 0);

        // R1/R4: whole image in one sequential read, ending with wrap to 0.
        do_read(1'b1, 8'd0, 256, "R1 power-on image");
        check(mptr == 8'd0, "R4 pointer wrapped", mptr, 0);
        do_read(1'b0, 8'd0, 2, "R4 continue after wrap");

        // R3: pointer set then read in a fresh transfer.
        do_write(8'd3, 0, 8'd0, 1'b0);
        do_read(1'b0, 8'd0, 2, "R3 read at set pointer");

        // R5/R7: unlocked lower write breaks the checksum, fixing byte 63 restores it.
        lock_en = 1'b0;
        do_write(8'd10, 1, 8'h55, 1'b0);
        check(csum_bad == 1'b1, "R7 mismatch raised", csum_bad, 1);
        do_write(8'd63, 1, 8'hA6 + 8'h55, 1'b0);
        check(csum_bad == 1'b0, "R7 mismatch cleared", csum_bad, 0);
        do_read(1'b1, 8'd8, 4, "R5 stored lower byte");

        // R6: locked lower half refused, upper half still written.
        lock_en = 1'b1;
        do_write(8'd126, 4, 8'hC0, 1'b0);
        do_read(1'b1, 8'd126, 4, "R6 lock boundary");
        do_write(8'd20, 1, 8'hEE, 1'b0);
        do_read(1'b1, 8'd20, 1, "R6 locked byte unchanged");

        // R5: write sequence wrapping 255 -> 0 with lock off.
        lock_en = 1'b0;
        do_write(8'd254, 4, 8'h31, 1'b0);
        check(mptr == 8'd2, "R5 write pointer wrap", mptr, 2);
        do_read(1'b1, 8'd254, 4, "R5 wrapped write data");

        // R2: wrong straps in the address byte are not acknowledged.
        strap = 3'b101;
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, nk);
        check(nk == 1'b1, "R2 foreign address ignored", nk, 1);
        send_byte(8'd40, nk);
        send_byte(8'h99, nk);
        bus_stop();
        do_read(1'b1, 8'd40, 1, "R2 memory untouched by foreign transfer");
        bus_start();
        send_byte({4'b1011, 3'b101, 1'b0}, nk);
        check(nk == 1'b1, "R2 wrong prefix ignored", nk, 1);
        bus_stop();

        // R8: STOP part-way through a data byte discards it.
        bus_start();
        send_byte(dev(1'b0), nk);
        send_byte(8'd50, nk);
        mptr = 8'd50;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check(sda_oe == 1'b0, "R8 released after early STOP", sda_oe, 0);
        do_read(1'b0, 8'd0, 1, "R8 partial byte not stored");

        // R8: repeated START part-way through a data byte, then read from pointer.
        bus_start();
        send_byte(dev(1'b0), nk);
        send_byte(8'd4, nk);
        mptr = 8'd4;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
        send_byte(dev(1'b1), nk);
        check(!nk, "R8 address accepted after repeated START", nk, 0);
        recv_byte(1'b1, b);
        check(b == 8'h0A, "R8 read after aborted byte", b, 8'h0A);
        bus_stop();

        // Random mix of straps, lock settings, writes and reads.
        for (int t = 0; t < 18; t++) begin
            strap   = 3'($urandom);
            lock_en = 1'($urandom);
            if ($urandom % 2 == 0)
                do_write(8'($urandom), 1 + int'($urandom % 4), 8'd0, 1'b1);
            else
                do_read(1'b1, 8'($urandom), 1 + int'($urandom % 4), "R4 random read");
        end
        do_read(1'b1, 8'd0, 64, "R7 final lower image");
        check(csum_bad == exp_bad(), "R7 final status", csum_bad, exp_bad());

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule